// File: doc/BRIEF.md
# Peripheral Bus Decoder with Open-Bus Reads

This block sits between a processor load/store port and a handful of narrow peripheral registers. It removes the segment bits from each incoming address, so every mirror of a register reaches the same place. It then sends byte, halfword and word accesses to the register that matches. An access that matches nothing completes normally. On a read it returns all ones at the access width.

Two byte-wide serial data ports need special handling. A halfword or word access to either port becomes a train of single-byte transfers, one per cycle and lowest byte first. The processor port stays busy until the train finishes, and read bytes are packed little-endian. A 16-bit interrupt status register is also reachable through the block: a read returns the value presented at its input, and a write raises a one-cycle strobe that carries the data.

Data is right-aligned on the processor side. The access size code is 0 for a byte, 1 for a halfword and 2 for a word, and code 3 behaves like a word. A request is a single-cycle pulse on `cpu_req`. It is accepted only while `cpu_busy` is low.

Top module: `pbus_decoder`

## Requirements
- R1: After synchronous reset, `cpu_busy`, `cpu_done`, `stat_wr` and every `ser_push`/`ser_pop` bit are 0.
- R2: The top three address bits are ignored: an access to `addr | (s << 29)` for any s in 0..7 behaves exactly like one to the masked address.
- R3: A read of the status register at 0x1F801070 completes one cycle after acceptance. It returns `stat_in` zero-extended for halfword and word accesses, and only `stat_in[7:0]` for a byte access.
- R4: A write to the status register pulses `stat_wr` for one cycle, together with `cpu_done`. `stat_wdata` carries `wdata[15:0]` for halfword and word writes, and `{8'h00, wdata[7:0]}` for byte writes.
- R5: A byte read of serial port 0 at 0x1F801040 issues exactly one `ser_pop[0]` and returns the popped byte in bits [7:0], with the upper bits zero.
- R6: A halfword or word read of a serial port issues 2 or 4 pops on consecutive cycles. The first popped byte lands in bits [7:0], the next in [15:8], and so on.
- R7: A write to a serial port issues 1, 2 or 4 pushes on consecutive cycles for a byte, halfword or word access. `ser_wbyte` carries `wdata[7:0]` first, then the higher bytes in ascending order.
- R8: A serial-port access of n bytes holds `cpu_busy` high during the n strobe cycles and raises `cpu_done` for one cycle in the cycle after the last strobe. Any other access raises `cpu_done` in the cycle after acceptance, with no busy period.
- R9: A request made while `cpu_busy` is high is dropped: it causes no strobe and no extra `cpu_done`.
- R10: A read that matches no location completes one cycle after acceptance and returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for byte, halfword or word.
- R11: A write that matches no location completes without any `ser_push` or `stat_wr`.
- R12: Serial port 1 sits at 0x1F801050, one 16-byte stride above port 0. It has its own strobe bit and byte lane, and accesses to one port never strobe the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request pulse |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpu_addr | input | 32 | Virtual address, segment bits included |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_busy | output | 1 | A byte train is in progress; requests are dropped |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid while cpu_done is high |
| ser_push | output | NPORT | Per-port byte write strobe |
| ser_pop | output | NPORT | Per-port byte read strobe |
| ser_wbyte | output | 8 | Byte written on the active push |
| ser_rbyte | input | 8*NPORT | Head byte of each port, lane p at [8p+7:8p] |
| stat_in | input | 16 | Current status register value |
| stat_wr | output | 1 | Status register write strobe |
| stat_wdata | output | 16 | Status register write data |

## Verification
The assertions assume three things about the inputs. First, `cpu_req` is a single-cycle pulse whose companion inputs are stable in that cycle. Second, `stat_in` does not change between acceptance and completion. Third, each serial port presents its head byte combinationally and advances only on a sampled pop. The stimulus drives every input at the falling edge, pulses `cpu_req` for exactly one cycle, and models each port as a counter-indexed byte sequence that steps on the rising edge when its pop bit is high. One sequence deliberately raises a request while the block is busy.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_STAT = 2'd1,
        TGT_SER  = 2'd2
    } target_e;

    localparam int PORT_IDX_W = 4;

    localparam logic [31:0] PHYS_MASK = 32'h1FFF_FFFF;

    typedef struct packed {
        target_e                tgt;
        logic [PORT_IDX_W-1:0]  port;
    } dec_t;

    typedef struct packed {
        logic                   we;
        acc_size_e              size;
        logic [31:0]            wdata;
        logic [PORT_IDX_W-1:0]  port;
    } seq_cmd_t;

    function automatic logic [31:0] phys_addr(input logic [31:0] a);
        return a & PHYS_MASK;
    endfunction

    function automatic logic [2:0] byte_count(input acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] fit_width(input logic [31:0] v, input acc_size_e s);
        case (s)
            SZ_BYTE: return {24'h0, v[7:0]};
            SZ_HALF: return {16'h0, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [31:0] open_bus(input acc_size_e s);
        return fit_width(32'hFFFF_FFFF, s);
    endfunction

endpackage

// File: rtl/pbus_decode.sv
module pbus_decode
    import pbus_pkg::*;
#(
    parameter int          NPORT      = 2,
    parameter logic [31:0] SER_BASE   = 32'h1F80_1040,
    parameter logic [31:0] SER_STRIDE = 32'h0000_0010,
    parameter logic [31:0] STAT_ADDR  = 32'h1F80_1070
) (
    input  logic [31:0] addr,
    output dec_t        dec
);

    logic [31:0]      pa;
    logic [NPORT-1:0] hit;

    assign pa = phys_addr(addr);

    for (genvar g = 0; g < NPORT; g++) begin : g_port_match
        localparam logic [31:0] PORT_ADDR = SER_BASE + 32'(g) * SER_STRIDE;
        assign hit[g] = (pa == PORT_ADDR);
    end

    always_comb begin
        dec.tgt  = TGT_NONE;
        dec.port = '0;
        if (|hit) begin
            dec.tgt = TGT_SER;
            for (int i = NPORT - 1; i >= 0; i--) begin
                if (hit[i]) dec.port = PORT_IDX_W'(i);
            end
        end else if (pa == STAT_ADDR) begin
            dec.tgt = TGT_STAT;
        end
    end

endmodule

// File: rtl/pbus_byte_seq.sv
module pbus_byte_seq
    import pbus_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  seq_cmd_t           cmd,
    input  logic [NPORT*8-1:0] rbyte_all,
    output logic               busy,
    output logic               fin,
    output logic [31:0]        acc,
    output logic [NPORT-1:0]   push,
    output logic [NPORT-1:0]   pop,
    output logic [7:0]         wbyte
);

    seq_cmd_t    cmd_q;
    logic [1:0]  idx_q;
    logic        busy_q;
    logic        fin_q;
    logic [31:0] acc_q;
    logic [7:0]  cur_byte;
    logic [2:0]  nb;
    logic        last;

    assign nb    = byte_count(cmd_q.size);
    assign last  = ({1'b0, idx_q} == (nb - 3'd1));
    assign wbyte = cmd_q.wdata[{idx_q, 3'b000} +: 8];

    always_comb begin
        cur_byte = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (cmd_q.port == PORT_IDX_W'(i)) cur_byte = rbyte_all[i*8 +: 8];
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_strobe
        assign push[g] = busy_q &&  cmd_q.we && (cmd_q.port == PORT_IDX_W'(g));
        assign pop[g]  = busy_q && !cmd_q.we && (cmd_q.port == PORT_IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
            idx_q  <= '0;
            acc_q  <= '0;
            cmd_q  <= '0;
        end else begin
            fin_q <= 1'b0;
            if (!busy_q && start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                acc_q  <= '0;
                cmd_q  <= cmd;
            end else if (busy_q) begin
                if (!cmd_q.we) acc_q[{idx_q, 3'b000} +: 8] <= cur_byte;
                if (last) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 2'd1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign fin  = fin_q;
    assign acc  = acc_q;

    // R6/R7: byte transfers step through consecutive lanes without gaps
    p_lane_step_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> (busy_q && idx_q == $past(idx_q) + 2'd1));

    // R8: the train never runs past its byte count
    p_lane_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ({1'b0, idx_q} < nb));

    // R8: completion follows the last lane by one cycle
    p_fin_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && last) |=> (fin_q && !busy_q));

endmodule

// File: rtl/pbus_decoder.sv
module pbus_decoder
    import pbus_pkg::*;
#(
    parameter int          NPORT      = 2,
    parameter logic [31:0] SER_BASE   = 32'h1F80_1040,
    parameter logic [31:0] SER_STRIDE = 32'h0000_0010,
    parameter logic [31:0] STAT_ADDR  = 32'h1F80_1070
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [1:0]         cpu_size,
    input  logic [31:0]        cpu_addr,
    input  logic [31:0]        cpu_wdata,
    output logic               cpu_busy,
    output logic               cpu_done,
    output logic [31:0]        cpu_rdata,
    output logic [NPORT-1:0]   ser_push,
    output logic [NPORT-1:0]   ser_pop,
    output logic [7:0]         ser_wbyte,
    input  logic [NPORT*8-1:0] ser_rbyte,
    input  logic [15:0]        stat_in,
    output logic               stat_wr,
    output logic [15:0]        stat_wdata
);

    dec_t        dec;
    acc_size_e   size;
    logic        accept;
    logic        seq_start;
    logic        seq_busy;
    logic        seq_fin;
    logic [31:0] seq_acc;
    seq_cmd_t    seq_cmd;
    logic        done_q;
    logic [31:0] rdata_q;

    assign size      = acc_size_e'(cpu_size);
    assign accept    = cpu_req && !seq_busy;
    assign seq_start = accept && (dec.tgt == TGT_SER);

    assign seq_cmd.we    = cpu_we;
    assign seq_cmd.size  = size;
    assign seq_cmd.wdata = cpu_wdata;
    assign seq_cmd.port  = dec.port;

    pbus_decode #(
        .NPORT      (NPORT),
        .SER_BASE   (SER_BASE),
        .SER_STRIDE (SER_STRIDE),
        .STAT_ADDR  (STAT_ADDR)
    ) u_decode (
        .addr (cpu_addr),
        .dec  (dec)
    );

    pbus_byte_seq #(
        .NPORT (NPORT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (seq_start),
        .cmd       (seq_cmd),
        .rbyte_all (ser_rbyte),
        .busy      (seq_busy),
        .fin       (seq_fin),
        .acc       (seq_acc),
        .push      (ser_push),
        .pop       (ser_pop),
        .wbyte     (ser_wbyte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q     <= 1'b0;
            rdata_q    <= '0;
            stat_wr    <= 1'b0;
            stat_wdata <= '0;
        end else begin
            done_q  <= accept && (dec.tgt != TGT_SER);
            stat_wr <= accept && cpu_we && (dec.tgt == TGT_STAT);
            if (accept && (dec.tgt != TGT_SER)) begin
                if (cpu_we)
                    rdata_q <= '0;
                else if (dec.tgt == TGT_STAT)
                    rdata_q <= fit_width({16'h0, stat_in}, size);
                else
                    rdata_q <= open_bus(size);
            end
            if (accept && cpu_we && (dec.tgt == TGT_STAT)) begin
                stat_wdata <= (size == SZ_BYTE) ? {8'h00, cpu_wdata[7:0]} : cpu_wdata[15:0];
            end
        end
    end

    assign cpu_busy  = seq_busy;
    assign cpu_done  = done_q || seq_fin;
    assign cpu_rdata = seq_fin ? seq_acc : rdata_q;

    // R12: at most one strobe of either kind on any port at a time
    p_single_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ser_push, ser_pop}));

    // R8: strobes only occur inside a busy period
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !cpu_busy |-> (ser_push == '0 && ser_pop == '0));

    // R8: the end of a busy period is a completion
    p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_busy) |-> cpu_done);

    // R10: unmapped reads complete next cycle with all ones at the width
    p_open_bus_r10: assert property (@(posedge clk) disable iff (rst)
        (accept && !cpu_we && dec.tgt == TGT_NONE) |=>
            (cpu_done && cpu_rdata == open_bus(acc_size_e'($past(cpu_size)))));

    // R11: unmapped writes touch no peripheral
    p_drop_write_r11: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_we && dec.tgt == TGT_NONE) |=>
            (cpu_done && !stat_wr && ser_push == '0));

    // R9: a request during a train starts nothing new
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_busy && !u_seq.last) |=> cpu_busy);

endmodule

// File: tb/tb_pbus_decoder.sv
module tb_pbus_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NPORT      = 2;

    logic               clk = 1'b0;
    logic               rst;
    logic               cpu_req;
    logic               cpu_we;
    logic [1:0]         cpu_size;
    logic [31:0]        cpu_addr;
    logic [31:0]        cpu_wdata;
    logic               cpu_busy;
    logic               cpu_done;
    logic [31:0]        cpu_rdata;
    logic [NPORT-1:0]   ser_push;
    logic [NPORT-1:0]   ser_pop;
    logic [7:0]         ser_wbyte;
    logic [NPORT*8-1:0] ser_rbyte;
    logic [15:0]        stat_in;
    logic               stat_wr;
    logic [15:0]        stat_wdata;

    int errors = 0;
    int checks = 0;
    int head [NPORT];

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_decoder dut (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_size   (cpu_size),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_busy   (cpu_busy),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata),
        .ser_push   (ser_push),
        .ser_pop    (ser_pop),
        .ser_wbyte  (ser_wbyte),
        .ser_rbyte  (ser_rbyte),
        .stat_in    (stat_in),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata)
    );

    function automatic logic [7:0] port_byte(input int p, input int h);
        return 8'((h * 37 + p * 101 + 5) & 255);
    endfunction

    initial begin
        for (int p = 0; p < NPORT; p++) head[p] = 0;
    end

    always @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) if (ser_pop[p] === 1'b1) head[p] = head[p] + 1;
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) ser_rbyte[p*8 +: 8] = port_byte(p, head[p]);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // kind: 0 = port 0, 1 = port 1, 2 = status register, 3 = unmapped
    task automatic access(input logic [31:0] addr, input logic [1:0] sz, input logic we,
                          input logic [31:0] wd, input int kind, input bit seg);
        int          nb;
        int          h0;
        int          k;
        int          lat;
        int          stat_pulses;
        bit          other;
        logic [31:0] exp_rd;
        logic [15:0] sval;
        logic [15:0] exp_sw;
        string       tg;
        nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        h0  = (kind < 2) ? head[kind] : 0;
        k   = 0;
        lat = 0;
        stat_pulses = 0;
        other = 1'b0;
        exp_sw = '0;
        @(negedge clk);
        sval      = stat_in;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_size  = sz;
        cpu_addr  = addr;
        cpu_wdata = wd;
        for (int it = 1; it <= 12; it++) begin
            @(negedge clk);
            cpu_req = 1'b0;
            if (stat_wr) begin
                stat_pulses++;
                exp_sw = (sz == 2'd0) ? {8'h00, wd[7:0]} : wd[15:0];
                tg = seg ? "R2" : "R4";
                chk(stat_wdata == exp_sw, tg, "status write data", stat_wdata, exp_sw);
            end
            for (int p = 0; p < NPORT; p++) begin
                if ((ser_push[p] || ser_pop[p]) && p != kind) other = 1'b1;
            end
            if (kind < 2 && (ser_push[kind] || ser_pop[kind])) begin
                if (we) begin
                    tg = seg ? "R2" : "R7";
                    chk(ser_push[kind] && k < 4 && ser_wbyte == wd[k*8 +: 8], tg,
                        "pushed byte", ser_wbyte, wd[(k%4)*8 +: 8]);
                end else begin
                    tg = seg ? "R2" : "R6";
                    chk(ser_pop[kind] == 1'b1, tg, "pop strobe kind", ser_pop[kind], 1);
                end
                k++;
            end
            if (cpu_done) begin
                lat = it;
                break;
            end
        end
        chk(!other, "R12", "strobe on foreign port", other, 0);
        if (kind < 2) begin
            tg = seg ? "R2" : (we ? "R7" : (nb == 1 ? "R5" : "R6"));
            chk(k == nb, tg, "byte transfer count", k, nb);
            tg = seg ? "R2" : "R8";
            chk(lat == nb + 1, tg, "port completion latency", lat, nb + 1);
            if (!we) begin
                exp_rd = '0;
                for (int b = 0; b < nb; b++) exp_rd[b*8 +: 8] = port_byte(kind, h0 + b);
                tg = seg ? "R2" : (kind == 1 ? "R12" : (nb == 1 ? "R5" : "R6"));
                chk(cpu_rdata == exp_rd, tg, "port read data", cpu_rdata, exp_rd);
            end
        end else begin
            tg = seg ? "R2" : "R8";
            chk(lat == 1 && k == 0, tg, "single-cycle completion", lat, 1);
            if (!we) begin
                if (kind == 2) begin
                    exp_rd = (sz == 2'd0) ? {24'h0, sval[7:0]} : {16'h0, sval};
                    tg = seg ? "R2" : "R3";
                end else begin
                    exp_rd = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
                    tg = seg ? "R2" : "R10";
                end
                chk(cpu_rdata == exp_rd, tg, "register read data", cpu_rdata, exp_rd);
            end
            tg = (kind == 2) ? "R4" : "R11";
            chk(stat_pulses == ((kind == 2 && we) ? 1 : 0), tg, "status strobe count",
                stat_pulses, (kind == 2 && we) ? 1 : 0);
        end
        @(negedge clk);
        chk(!cpu_done, "R8", "done lasts one cycle", cpu_done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] base [4];
        int          pushes;
        int          pops;
        int          dones;
        int          done_at;
        int          n;
        base[0] = 32'h1F80_1040;
        base[1] = 32'h1F80_1050;
        base[2] = 32'h1F80_1070;
        base[3] = 32'h1F80_1060;
        rst       = 1'b1;
        cpu_req   = 1'b0;
        cpu_we    = 1'b0;
        cpu_size  = 2'd0;
        cpu_addr  = '0;
        cpu_wdata = '0;
        stat_in   = 16'hC3A5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(!cpu_busy && !cpu_done && !stat_wr && ser_push == '0 && ser_pop == '0,
            "R1", "reset outputs", {cpu_busy, cpu_done, stat_wr, ser_push, ser_pop}, 0);

        n = 0;
        for (int s = 0; s < 8; s++) begin
            for (int kind = 0; kind < 4; kind++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int we = 0; we < 2; we++) begin
                        n++;
                        stat_in = 16'hC3A5 ^ 16'(n * 16'h0111);
                        access(base[kind] | (32'(s) << 29), 2'(sz), 1'(we),
                               32'h8C4E_2A17 ^ 32'(n * 32'h0101_0301), kind, s != 0);
                    end
                end
            end
        end

        // R11: unmapped address just below port 0 and status write of size 3
        access(32'h1F80_103C, 2'd2, 1'b1, 32'hDEAD_BEEF, 3, 1'b0);
        access(32'h1F80_1070, 2'd3, 1'b1, 32'h0000_5A5A, 2, 1'b0);

        // R9: request raised while a word read of port 0 is in progress
        pushes  = 0;
        pops    = 0;
        dones   = 0;
        done_at = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'd2; cpu_addr = 32'h1F80_1040;
        for (int it = 1; it <= 8; it++) begin
            @(negedge clk);
            cpu_req = 1'b0;
            if (it == 2) begin
                cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'd2;
                cpu_addr = 32'h1F80_1050; cpu_wdata = 32'h1122_3344;
            end
            if (ser_push != '0) pushes++;
            if (ser_pop != '0) pops++;
            if (cpu_done) begin
                dones++;
                done_at = it;
            end
        end
        chk(pushes == 0, "R9", "pushes from dropped request", pushes, 0);
        chk(pops == 4, "R9", "pops of accepted request", pops, 4);
        chk(dones == 1 && done_at == 5, "R9", "completions", dones * 100 + done_at, 105);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule